// File: doc/BRIEF.md
# Panel Raster Timing Generator

The block produces the raster timing for a parallel RGB display panel. It runs from the dot clock and counts dots, 8-dot characters and lines. From those counts it derives the horizontal sync, the vertical sync, a data-enable strobe, a half-rate dot reference, the current pixel column and line, and one-cycle pulses that mark the start and the end of each frame.

Horizontal geometry is programmed in 8-dot characters: the total line length, the active width, the column where sync starts and the sync length. Vertical geometry is programmed in whole lines: the total frame height, the active line count, the line where sync starts and the sync length. Four independent bits set the polarity of the outputs. One makes horizontal sync active-low, one makes vertical sync active-low, one inverts data enable and one inverts the dot reference.

The configuration is captured only while the block is stopped and is then frozen for the whole run. Deasserting `run` returns the counters to zero and drives every output to its inactive level.

Top module: `lcdtg_top`

## Requirements
- R1: While `run` is low, or after reset, `pix_x` and `line_y` are 0 and both frame pulses are low. `hsync` equals `cfg_hsync_low`, `vsync` equals `cfg_vsync_low`, `de` equals `cfg_de_invert` and `dot_ref` equals `cfg_dotref_invert`, using the values held by the block.
- R2: The first clock edge that samples `run` high starts the run at position (column 0, line 0). Each later edge advances the column by one dot. `pix_x` equals character*8 + dot-within-character. After `cfg_htotal`*8 dots the column returns to 0 and the line advances. After `cfg_vtotal` lines the line returns to 0.
- R3: Horizontal sync is active on every line while character c satisfies `cfg_hsync_start` <= c < `cfg_hsync_start` + `cfg_hsync_width`.
- R4: Vertical sync is active for whole lines while line l satisfies `cfg_vsync_start` <= l < `cfg_vsync_start` + `cfg_vsync_width`. A width of 0 gives no vertical sync.
- R5: Data enable is active exactly when the character is below `cfg_hactive` and the line is below `cfg_vactive`.
- R6: `frame_start` is high for one cycle at column 0 of line 0. `frame_end` is high for one cycle at column `cfg_hactive`*8 of line `cfg_vactive`-1, which is the cycle after the last active pixel. This requires 1 <= `cfg_hactive` < `cfg_htotal`.
- R7: While running, `dot_ref` equals bit 0 of `pix_x` XOR `cfg_dotref_invert`.
- R8: A set polarity bit makes its output low when active and high when inactive. A clear bit gives an active-high output. Each of the four bits acts on its own output only.
- R9: The configuration inputs are captured only on clock edges where the block is stopped. Changes made while it runs have no effect on any output until the next stop.
- R10: Deasserting `run` in mid-frame and asserting it again restarts at column 0, line 0 with a new `frame_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Counting enable; low holds the block stopped |
| cfg_htotal | input | CH_W | Line length in characters |
| cfg_hactive | input | CH_W | Active width in characters |
| cfg_hsync_start | input | CH_W | Character where horizontal sync starts |
| cfg_hsync_width | input | CH_W | Horizontal sync length in characters |
| cfg_vtotal | input | LN_W | Frame height in lines |
| cfg_vactive | input | LN_W | Active line count |
| cfg_vsync_start | input | LN_W | Line where vertical sync starts |
| cfg_vsync_width | input | LN_W | Vertical sync length in lines |
| cfg_hsync_low | input | 1 | Horizontal sync is active-low |
| cfg_vsync_low | input | 1 | Vertical sync is active-low |
| cfg_de_invert | input | 1 | Invert data enable |
| cfg_dotref_invert | input | 1 | Invert dot reference |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| dot_ref | output | 1 | Half-rate dot reference |
| pix_x | output | CH_W+3 | Current dot column |
| line_y | output | LN_W | Current line |
| frame_start | output | 1 | One-cycle pulse at the first dot of a frame |
| frame_end | output | 1 | One-cycle pulse after the last active pixel |

## Verification
The geometry is drawn at random from a fixed seed and covers small totals, every active width below the total, and sync windows that may run past the end of the line or frame. Each output is compared against a position derived from the elapsed cycle count, so an error in the wrap points, the character stepping or the window bounds shows up at once. Directed cases cover the corner geometries: active width one character short of the total, a vertical sync of zero width, and all polarity bits set. Other directed cases change the configuration while running, which separates a latch that stays frozen from one that follows its inputs. A mid-frame stop and restart shows whether the counters clear and whether `frame_start` is raised again.

// File: rtl/lcdtg_pkg.sv
package lcdtg_pkg;
  // Position inside [start, start+width); a width of 0 is an empty window.
  function automatic logic in_span(input logic [15:0] pos,
                                   input logic [15:0] start,
                                   input logic [15:0] width);
    logic [16:0] stop;
    stop = {1'b0, start} + {1'b0, width};
    return ({1'b0, pos} >= {1'b0, start}) && ({1'b0, pos} < stop);
  endfunction

  // True when cnt is the final step of a cycle of length total.
  function automatic logic at_last(input logic [15:0] cnt,
                                   input logic [15:0] total);
    return (cnt == total - 16'd1);
  endfunction
endpackage

// File: rtl/lcdtg_cfg_hold.sv
module lcdtg_cfg_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= '0;
    else if (capture) q <= d;
  end

  // R9: no capture on the previous edge means the held value is unchanged
  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(capture) |-> $stable(q));
endmodule

// File: rtl/lcdtg_hcount.sv
module lcdtg_hcount
  import lcdtg_pkg::*;
#(
  parameter int CH_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            running,
  input  logic [CH_W-1:0] htotal,
  output logic [2:0]      sub,
  output logic [CH_W-1:0] hch,
  output logic            line_step
);
  logic advance;
  logic char_done;
  assign advance   = run && running;
  assign char_done = (sub == 3'd7);
  assign line_step = advance && char_done && at_last(16'(hch), 16'(htotal));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub <= '0;
      hch <= '0;
    end else if (!run) begin
      sub <= '0;
      hch <= '0;
    end else if (advance) begin
      sub <= sub + 3'd1;
      if (char_done) hch <= line_step ? '0 : hch + 1'b1;
    end
  end

  p_sub_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !char_done) |=> (sub == $past(sub) + 3'd1));
  p_sub_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && char_done) |=> (sub == 3'd0));
  p_hch_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (running && htotal != '0) |-> (hch < htotal));
endmodule

// File: rtl/lcdtg_vcount.sv
module lcdtg_vcount
  import lcdtg_pkg::*;
#(
  parameter int LN_W = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            line_step,
  input  logic [LN_W-1:0] vtotal,
  output logic [LN_W-1:0] vln
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         vln <= '0;
    else if (!run)      vln <= '0;
    else if (line_step) vln <= at_last(16'(vln), 16'(vtotal)) ? '0 : vln + 1'b1;
  end

  p_line_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (vtotal != '0 && $past(vtotal) == vtotal) |-> (vln < vtotal));
endmodule

// File: rtl/lcdtg_top.sv
module lcdtg_top
  import lcdtg_pkg::*;
#(
  parameter int CH_W = 8,
  parameter int LN_W = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [CH_W-1:0] cfg_htotal,
  input  logic [CH_W-1:0] cfg_hactive,
  input  logic [CH_W-1:0] cfg_hsync_start,
  input  logic [CH_W-1:0] cfg_hsync_width,
  input  logic [LN_W-1:0] cfg_vtotal,
  input  logic [LN_W-1:0] cfg_vactive,
  input  logic [LN_W-1:0] cfg_vsync_start,
  input  logic [LN_W-1:0] cfg_vsync_width,
  input  logic            cfg_hsync_low,
  input  logic            cfg_vsync_low,
  input  logic            cfg_de_invert,
  input  logic            cfg_dotref_invert,
  output logic            hsync,
  output logic            vsync,
  output logic            de,
  output logic            dot_ref,
  output logic [CH_W+2:0] pix_x,
  output logic [LN_W-1:0] line_y,
  output logic            frame_start,
  output logic            frame_end
);
  localparam int CFG_W = 4 * CH_W + 4 * LN_W + 4;

  logic             running;
  logic [CFG_W-1:0] cfg_d, cfg_q;
  logic [CH_W-1:0]  htot, hact, hs_pos, hs_wid;
  logic [LN_W-1:0]  vtot, vact, vs_pos, vs_wid;
  logic             hs_lo, vs_lo, de_inv, dr_inv;
  logic [2:0]       sub;
  logic [CH_W-1:0]  hch;
  logic [LN_W-1:0]  vln;
  logic             line_step;

  // Named internal events
  logic hs_act, vs_act, de_act, at_origin, after_last_px;

  assign cfg_d = {cfg_htotal, cfg_hactive, cfg_hsync_start, cfg_hsync_width,
                  cfg_vtotal, cfg_vactive, cfg_vsync_start, cfg_vsync_width,
                  cfg_hsync_low, cfg_vsync_low, cfg_de_invert, cfg_dotref_invert};

  lcdtg_cfg_hold #(.W(CFG_W)) cfg_i (
    .clk(clk), .rst_n(rst_n), .capture(!running), .d(cfg_d), .q(cfg_q));

  assign {htot, hact, hs_pos, hs_wid, vtot, vact, vs_pos, vs_wid,
          hs_lo, vs_lo, de_inv, dr_inv} = cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) running <= 1'b0;
    else        running <= run;
  end

  lcdtg_hcount #(.CH_W(CH_W)) hcnt_i (
    .clk(clk), .rst_n(rst_n), .run(run), .running(running), .htotal(htot),
    .sub(sub), .hch(hch), .line_step(line_step));

  lcdtg_vcount #(.LN_W(LN_W)) vcnt_i (
    .clk(clk), .rst_n(rst_n), .run(run), .line_step(line_step),
    .vtotal(vtot), .vln(vln));

  assign hs_act        = running && in_span(16'(hch), 16'(hs_pos), 16'(hs_wid));
  assign vs_act        = running && in_span(16'(vln), 16'(vs_pos), 16'(vs_wid));
  assign de_act        = running && (hch < hact) && (vln < vact);
  assign at_origin     = running && (sub == 3'd0) && (hch == '0) && (vln == '0);
  assign after_last_px = running && (sub == 3'd0) && (hch == hact) &&
                         at_last(16'(vln), 16'(vact));

  assign hsync       = hs_act ^ hs_lo;
  assign vsync       = vs_act ^ vs_lo;
  assign de          = de_act ^ de_inv;
  assign dot_ref     = (running & sub[0]) ^ dr_inv;
  assign pix_x       = {hch, sub};
  assign line_y      = vln;
  assign frame_start = at_origin;
  assign frame_end   = after_last_px;

  p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (pix_x == '0 && line_y == '0 && !frame_start && !frame_end));
  p_pulse_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({frame_start, frame_end}));
  p_start_origin_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !running) |=> (pix_x == '0 && line_y == '0));
  p_de_region_r5: assert property (@(posedge clk) disable iff (!rst_n)
    de_act |-> (line_y < vact && pix_x < {hact, 3'b000}));
  p_fe_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !frame_end);
endmodule

// File: tb/lcdtg_top_tb_top.sv
`timescale 1ns/1ps
module lcdtg_top_tb_top;
  localparam int CH_W = 8;
  localparam int LN_W = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  logic [CH_W-1:0] c_ht, c_ha, c_hp, c_hw;
  logic [LN_W-1:0] c_vt, c_va, c_vp, c_vw;
  logic c_hl, c_vl, c_di, c_ri;
  logic hsync, vsync, de, dot_ref, frame_start, frame_end;
  logic [CH_W+2:0] pix_x;
  logic [LN_W-1:0] line_y;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  // model configuration (what the block should be using)
  int m_ht, m_ha, m_hp, m_hw, m_vt, m_va, m_vp, m_vw;
  bit m_hl, m_vl, m_di, m_ri;

  always #10 clk = ~clk;

  lcdtg_top #(.CH_W(CH_W), .LN_W(LN_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .run(run),
    .cfg_htotal(c_ht), .cfg_hactive(c_ha), .cfg_hsync_start(c_hp), .cfg_hsync_width(c_hw),
    .cfg_vtotal(c_vt), .cfg_vactive(c_va), .cfg_vsync_start(c_vp), .cfg_vsync_width(c_vw),
    .cfg_hsync_low(c_hl), .cfg_vsync_low(c_vl), .cfg_de_invert(c_di), .cfg_dotref_invert(c_ri),
    .hsync(hsync), .vsync(vsync), .de(de), .dot_ref(dot_ref),
    .pix_x(pix_x), .line_y(line_y), .frame_start(frame_start), .frame_end(frame_end));

  task automatic check(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, got, exp, $time);
    end
  endtask

  function automatic bit win(input int p, input int s, input int w);
    return (p >= s) && (p - s < w);
  endfunction

  task automatic drive_cfg(input int ht, input int ha, input int hp, input int hw,
                           input int vt, input int va, input int vp, input int vw,
                           input bit hl, input bit vl, input bit di, input bit ri);
    c_ht = CH_W'(ht); c_ha = CH_W'(ha); c_hp = CH_W'(hp); c_hw = CH_W'(hw);
    c_vt = LN_W'(vt); c_va = LN_W'(va); c_vp = LN_W'(vp); c_vw = LN_W'(vw);
    c_hl = hl; c_vl = vl; c_di = di; c_ri = ri;
  endtask

  task automatic model_from_inputs();
    m_ht = int'(c_ht); m_ha = int'(c_ha); m_hp = int'(c_hp); m_hw = int'(c_hw);
    m_vt = int'(c_vt); m_va = int'(c_va); m_vp = int'(c_vp); m_vw = int'(c_vw);
    m_hl = c_hl; m_vl = c_vl; m_di = c_di; m_ri = c_ri;
  endtask

  // Stopped-state outputs (R1, R8)
  task automatic check_idle(input string tag);
    check("R1", {tag, " pix_x"}, int'(pix_x), 0);
    check("R1", {tag, " line_y"}, int'(line_y), 0);
    check("R1", {tag, " frame_start"}, int'(frame_start), 0);
    check("R1", {tag, " frame_end"}, int'(frame_end), 0);
    check("R1", {tag, " hsync idle (R8)"}, int'(hsync), int'(m_hl));
    check("R1", {tag, " vsync idle (R8)"}, int'(vsync), int'(m_vl));
    check("R1", {tag, " de idle (R8)"}, int'(de), int'(m_di));
    check("R1", {tag, " dot_ref idle"}, int'(dot_ref), int'(m_ri));
  endtask

  // Compare all outputs at elapsed cycle t since the run started
  task automatic check_at(input int t);
    int ppl, r, ln, x, ch;
    ppl = m_ht * 8;
    r   = t % (ppl * m_vt);
    ln  = r / ppl;
    x   = r % ppl;
    ch  = x / 8;
    check("R2", "pix_x", int'(pix_x), x);
    check("R2", "line_y", int'(line_y), ln);
    check("R3", "hsync", int'(hsync), int'(win(ch, m_hp, m_hw) ^ m_hl));
    check("R4", "vsync", int'(vsync), int'(win(ln, m_vp, m_vw) ^ m_vl));
    check("R5", "de", int'(de), int'(((ch < m_ha) && (ln < m_va)) ^ m_di));
    check("R6", "frame_start", int'(frame_start), int'(r == 0));
    check("R6", "frame_end", int'(frame_end), int'((ln == m_va - 1) && (x == m_ha * 8)));
    check("R7", "dot_ref", int'(dot_ref), (x & 1) ^ int'(m_ri));
  endtask

  // Start with the driven configuration, check n cycles; optionally
  // scramble the inputs at cycle chg (R9).
  task automatic run_and_check(input int n, input int chg);
    repeat (3) @(negedge clk);
    model_from_inputs();
    check_idle("pre-run");
    run = 1'b1;
    @(negedge clk);
    for (int t = 0; t < n; t++) begin
      if (t == chg) begin
        // R9: these values must be ignored while running
        drive_cfg(1 + $urandom % 9, $urandom % 9, $urandom % 9, $urandom % 9,
                  1 + $urandom % 9, $urandom % 9, $urandom % 9, $urandom % 9,
                  ~m_hl, ~m_vl, ~m_di, ~m_ri);
      end
      check_at(t);
      @(negedge clk);
    end
    run = 1'b0;
    @(negedge clk);
    @(negedge clk);
    model_from_inputs();
    check_idle("after stop R10");
  endtask

  initial begin
    int ht, ha, vt, va;
    void'($urandom(32'd20240611));
    drive_cfg(4, 3, 3, 1, 5, 4, 4, 1, 1'b0, 1'b0, 1'b0, 1'b0);
    model_from_inputs();
    repeat (3) @(negedge clk);
    check_idle("reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("post-reset");

    // Directed: active one char short of total, sync at line end
    drive_cfg(5, 4, 4, 1, 6, 5, 5, 1, 1'b0, 1'b0, 1'b0, 1'b0);
    run_and_check(2 * 5 * 8 * 6 + 3, -1);
    // Directed: zero-width vertical sync, all polarities inverted (R8)
    drive_cfg(3, 2, 1, 1, 4, 2, 1, 0, 1'b1, 1'b1, 1'b1, 1'b1);
    run_and_check(2 * 3 * 8 * 4 + 3, -1);
    // Directed: config change mid-run is ignored (R9)
    drive_cfg(4, 2, 2, 3, 5, 3, 3, 2, 1'b1, 1'b0, 1'b0, 1'b1);
    run_and_check(2 * 4 * 8 * 5, 37);
    // Directed: stop mid-frame, restart from origin (R10)
    drive_cfg(3, 1, 1, 1, 3, 2, 2, 1, 1'b0, 1'b1, 1'b1, 1'b0);
    run_and_check(50, -1);
    run_and_check(3 * 8 * 3 + 5, -1);

    // Random geometries
    for (int k = 0; k < 8; k++) begin
      ht = 2 + $urandom % 6;
      ha = 1 + $urandom % (ht - 1);
      vt = 2 + $urandom % 7;
      va = 1 + $urandom % (vt - 1);
      drive_cfg(ht, ha, $urandom % (ht + 1), $urandom % 4,
                vt, va, $urandom % (vt + 1), $urandom % 3,
                1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      run_and_check(2 * ht * 8 * vt + 2, (k % 2 == 1) ? 20 : -1);
    end

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog R2 actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule